// File: doc/BRIEF.md
# Fractional-Ratio Square Wave Divider

This block turns a fast reference clock into a slow square wave whose period is a non-integer number of reference cycles. It is sized by default for a 50 MHz reference and a 300 Hz output, where one ideal period is 166666.67 reference cycles. A plain integer divider of 166666 would run about 4 ppm fast, and that error would add up over time. This block avoids it by giving successive output periods slightly different lengths.

A down-counter times each half of the current period. A three-step slot sequencer picks the length of each new period. Slots 0 and 1 use the long count, and slot 2 uses the short count. The sum of any three consecutive periods is therefore exactly `2*LONG_CYC + SHORT_CYC` reference cycles, which is 500000 with the defaults. The output phase stays bounded and does not drift.

Each period starts with the high half and ends with the low half. A one-cycle marker is raised on the cycle in which the wave rises. Other ratios with a denominator of 3 can reuse the block by setting the two length parameters, with both lengths at least 2.

Top module: `fdiv_square`

## Requirements
- R1: While `rst` is high at a clock edge, `sq_out` and `period_start` are 0. The first edge with `rst` low starts a period in slot 0, so `sq_out` and `period_start` are both 1 in the following cycle.
- R2: Period slots run in the order 0, 1, 2 and then wrap to 0. The distance between consecutive `period_start` pulses is LONG_CYC after a slot 0 or slot 1 period and SHORT_CYC after a slot 2 period.
- R3: Any three consecutive periods together last exactly 2*LONG_CYC + SHORT_CYC reference cycles. This is measured between the `period_start` pulses of period n and period n+3.
- R4: A period of P cycles holds `sq_out` high for the first ceil(P/2) cycles and low for the remaining floor(P/2) cycles.
- R5: `period_start` is high for exactly one cycle per period. It is high precisely in the cycles where `sq_out` has just gone from 0 to 1.
- R6: The slot sequencer moves forward exactly once per period, on the same edge that begins the next period.
- R7: A reset asserted partway through a period forces both outputs to 0. After the reset is released, the output restarts from slot 0 with the full R1 to R4 pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sq_out | output | 1 | Divided square wave, high half first |
| period_start | output | 1 | One-cycle marker on the cycle the wave rises |

## Verification
A slot sequencer that skips a step or advances twice shows up within one period: a pulse spacing of the wrong length appears, and the three-period sum no longer matches. A down-counter reloaded with a wrong value, or a stale low-half length, moves the falling edge of `sq_out` within the same period. A marker register out of step with the wave is caught on the very cycle the wave rises. The bench uses short lengths of 7 and 6 cycles so that these deviations appear after a few tens of cycles, and it compares both outputs with a behavioural model on every clock.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Number of slots in the period-length rotation.
    localparam int unsigned SEQ_STEPS = 3;

    // The high half takes the spare cycle of an odd period.
    function automatic int unsigned hi_part(input int unsigned p);
        return (p + 1) / 2;
    endfunction

    function automatic int unsigned lo_part(input int unsigned p);
        return p / 2;
    endfunction

endpackage

// File: rtl/fdiv_seq.sv
module fdiv_seq #(
    parameter int unsigned STEPS = 3,
    parameter int unsigned SW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [SW-1:0] slot_q
);
    localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

    logic [SW-1:0] slot_d;

    always_comb begin
        slot_d = slot_q;
        if (adv) begin
            slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    // R2: the slot never leaves its range, and it wraps after the last step
    a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
        slot_q <= LAST);
    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && slot_q == LAST) |=> (slot_q == '0));

endmodule

// File: rtl/fdiv_len.sv
module fdiv_len
    import fdiv_pkg::*;
#(
    parameter int unsigned LONG_CYC   = 166667,
    parameter int unsigned SHORT_CYC  = 166666,
    parameter int unsigned SHORT_SLOT = 2,
    parameter int unsigned SW         = 2,
    parameter int unsigned CW         = 18
) (
    input  logic [SW-1:0] slot,
    output logic [CW-1:0] hi_m1,
    output logic [CW-1:0] lo_m1
);
    localparam logic [CW-1:0] L_HI = CW'(hi_part(LONG_CYC) - 1);
    localparam logic [CW-1:0] L_LO = CW'(lo_part(LONG_CYC) - 1);
    localparam logic [CW-1:0] S_HI = CW'(hi_part(SHORT_CYC) - 1);
    localparam logic [CW-1:0] S_LO = CW'(lo_part(SHORT_CYC) - 1);

    generate
        if (LONG_CYC == SHORT_CYC) begin : g_integer
            // Degenerate case: the ratio is an integer, so no rotation is needed.
            logic unused_slot;
            assign unused_slot = ^slot;
            assign hi_m1 = L_HI;
            assign lo_m1 = L_LO;
        end else begin : g_fraction
            logic is_short;
            assign is_short = (slot == SW'(SHORT_SLOT));
            assign hi_m1 = is_short ? S_HI : L_HI;
            assign lo_m1 = is_short ? S_LO : L_LO;
        end
    endgenerate

endmodule

// File: rtl/fdiv_timer.sv
module fdiv_timer #(
    parameter int unsigned CW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R4: between reloads the half-period count steps down by one per cycle
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fdiv_square.sv
module fdiv_square
    import fdiv_pkg::*;
#(
    parameter int unsigned LONG_CYC   = 166667,
    parameter int unsigned SHORT_CYC  = 166666,
    parameter int unsigned SHORT_SLOT = 2
) (
    input  logic clk,
    input  logic rst,
    output logic sq_out,
    output logic period_start
);
    localparam int unsigned MAXP = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned CW   = $clog2(MAXP + 1);
    localparam int unsigned SW   = $clog2(SEQ_STEPS);

    typedef struct packed {
        logic          sq;
        logic          pulse;
        logic [CW-1:0] lo_m1;
    } div_state_t;

    div_state_t    st_d, st_q;
    logic [SW-1:0] slot_q;
    logic [CW-1:0] hi_m1, lo_m1;
    logic          done, load, adv;
    logic [CW-1:0] load_val;

    fdiv_seq #(.STEPS(SEQ_STEPS), .SW(SW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .slot_q (slot_q)
    );

    fdiv_len #(
        .LONG_CYC   (LONG_CYC),
        .SHORT_CYC  (SHORT_CYC),
        .SHORT_SLOT (SHORT_SLOT),
        .SW         (SW),
        .CW         (CW)
    ) u_len (
        .slot  (slot_q),
        .hi_m1 (hi_m1),
        .lo_m1 (lo_m1)
    );

    fdiv_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        load       = 1'b0;
        load_val   = '0;
        adv        = 1'b0;
        if (done) begin
            load = 1'b1;
            if (!st_q.sq) begin
                // Low half over (or reset just left): open the next period.
                st_d.sq    = 1'b1;
                st_d.pulse = 1'b1;
                st_d.lo_m1 = lo_m1;
                load_val   = hi_m1;
                adv        = 1'b1;
            end else begin
                st_d.sq  = 1'b0;
                load_val = st_q.lo_m1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sq_out       = st_q.sq;
    assign period_start = st_q.pulse;

    // R5: the marker appears only on a rising cycle, and every rise carries it
    a_r5_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |-> (st_q.sq && !$past(st_q.sq)));
    a_r5_rise_has_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.sq) |-> st_q.pulse);
    // R6: the slot changes only together with a period start
    a_r6_slot_moves_at_start: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && slot_q != $past(slot_q)) |-> st_q.pulse);

endmodule

// File: tb/fdiv_square_bench.sv
module fdiv_square_bench;
    localparam int LONG  = 7;
    localparam int SHORT = 6;
    localparam int TRIO  = 2 * LONG + SHORT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sq, ps;

    always #2 clk = ~clk;

    fdiv_square #(.LONG_CYC(LONG), .SHORT_CYC(SHORT), .SHORT_SLOT(2)) u_fdiv_square (
        .clk          (clk),
        .rst          (rst),
        .sq_out       (sq),
        .period_start (ps)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int k      = 0;
    int pos    = 0;
    int pulse_at[$];
    bit finished = 0;

    function automatic int plen(input int slot_n);
        return ((slot_n % 3) == 2) ? SHORT : LONG;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            int p;
            int hi;
            string req;
            @(negedge clk);
            cyc++;
            p   = plen(k);
            hi  = (p + 1) / 2;
            req = (k == 0 && pos == 0) ? "R1" : "R4";
            chk(sq == (pos < hi), req, "sq_out", int'(sq), int'(pos < hi));
            chk(ps == (pos == 0), "R5", "period_start", int'(ps), int'(pos == 0));
            if (ps) pulse_at.push_back(cyc);
            pos++;
            if (pos == p) begin
                pos = 0;
                k++;
            end
        end
    endtask

    task automatic check_spacing();
        for (int i = 0; i + 1 < pulse_at.size(); i++) begin
            chk(pulse_at[i+1] - pulse_at[i] == plen(i), "R2/R6", "pulse spacing",
                pulse_at[i+1] - pulse_at[i], plen(i));
        end
        for (int i = 0; i + 3 < pulse_at.size(); i++) begin
            chk(pulse_at[i+3] - pulse_at[i] == TRIO, "R3", "three-period span",
                pulse_at[i+3] - pulse_at[i], TRIO);
        end
    endtask

    task automatic hold_reset(input int n, input string req);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            chk(sq == 1'b0, req, "sq_out in reset", int'(sq), 0);
            chk(ps == 1'b0, req, "period_start in reset", int'(ps), 0);
        end
        rst = 1'b0;
        k   = 0;
        pos = 0;
        pulse_at.delete();
    endtask

    initial begin
        // R1: reset state, then the first period starts at once
        hold_reset(3, "R1");
        run_cycles(10 * TRIO);
        check_spacing();
        // R7: reset partway through a period, then a clean restart
        run_cycles(9);
        hold_reset(3, "R7");
        run_cycles(6 * TRIO + 5);
        check_spacing();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule